// File: doc/BRIEF.md
# Deferred Draw Command Collector

This block sits on the register-write path of a graphics command front end. Writes to draw-related methods are not acted on when they arrive. The block keeps their values, keeps a summary of which of them arrived, and unpacks inline index words into a byte queue. A batch is closed by a draw-end method. The batch is evaluated when the next write to any method outside the draw class arrives, provided the last logged draw-class write was draw end. Evaluation produces one draw request. The request carries an indexed/direct flag, an instance count, the element count and first element, and the index format.

The instance count comes from the draw-begin value. In instance mode, the block counts how many vertex-count or index-count writes were repeated inside the batch. In general mode the count is one, and an inline index stream replaces the index count with the number of 32-bit entries in the byte queue. The request is held on a ready/valid pair. While it is pending, the queue can be read byte by byte through a read port. The queue is emptied when the request is accepted.

Top module: `dd_collector`

## Requirements
- R1: Method codes 0x00 draw end, 0x01 draw begin, 0x02 vertex first, 0x03 vertex count, 0x04 index first, 0x05 index count, 0x06 inline 32-bit word, 0x07 inline 2x16, 0x08 inline 4x8 form the draw class. They are stored and logged. Every other code is a non-draw write.
- R2: The inline index writes push bytes into the queue, least significant byte first. Code 0x06 pushes its 4 data bytes. Code 0x07 pushes data[15:0] and then data[31:16], each zero-extended to 4 bytes. Code 0x08 pushes data bytes 0, 1, 2 and 3 in that order, each zero-extended to 4 bytes.
- R3: A batch is evaluated only when a non-draw write is accepted while the last logged method is draw end. Otherwise no request is made, and the log and the queue are kept.
- R4: Draw-begin data[1:0] selects the instance id: 0 first, 1 subsequent, 2 unchanged. For 1 or 2 (instance mode), the instance count equals the number of logged vertex-count writes, or the number of logged index-count writes.
- R5: If a batch in instance mode logs both kinds of count write, mix_err pulses for one cycle. The instance count is then the number of writes of the kind written most recently.
- R6: In general mode the instance count is 1. If an inline index write was logged, the index count becomes the queue byte count divided by 4, and the index format becomes 2 (32-bit unsigned).
- R7: A draw is indexed when the index count is nonzero and the vertex count is zero. draw_count and draw_first come from the chosen buffer. Afterwards only the count that was used is cleared to zero.
- R8: If render_en is low at evaluation, no request is issued. The used count is still cleared and the queue is emptied.
- R9: A request stays valid with stable fields until draw_ready. wr_ready is low while a request is pending. The queue stays readable until acceptance and is empty afterwards.
- R10: A draw-class write beyond LOG_DEPTH logged entries, or a push beyond QDEPTH bytes, sets ovf_err until the next evaluation. Writes beyond the log depth are not counted, and bytes beyond the queue depth are dropped.
- R11: After reset: no request is pending, wr_ready is high, the queue is empty, both error outputs are low, both counts are zero, the format is 0 and the instance id is first.
- R12: Code 0x10 writes the index format from data[1:0]. When this write also triggers an evaluation, the draw uses the previous format and the written value holds afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Method write offered |
| wr_ready | output | 1 | Method write accepted this cycle |
| wr_method | input | METHOD_W | Method code |
| wr_data | input | 32 | Method value |
| render_en | input | 1 | Render condition, sampled at evaluation |
| draw_valid | output | 1 | Draw request pending |
| draw_ready | input | 1 | Consumer takes the request |
| draw_indexed | output | 1 | Indexed (1) or direct (0) draw |
| draw_instances | output | LW | Instance count |
| draw_count | output | 32 | Element count of the chosen buffer |
| draw_first | output | 32 | First element of the chosen buffer |
| draw_fmt | output | 2 | Index format code |
| ixq_raddr | input | QAW | Byte queue read address |
| ixq_rdata | output | 8 | Byte queue read data |
| ixq_bytes | output | QCW | Bytes held in the queue |
| ovf_err | output | 1 | Log or queue overflow in the current batch |
| mix_err | output | 1 | Both count kinds in an instance-mode batch |

## Verification
The bench targets the case where a non-draw write arrives without a preceding draw end. A design that evaluates eagerly would issue a draw there and lose the accumulated counts. It also checks that only the used count is cleared: a design that zeroes both counts would turn the following batch from indexed into direct. Mixed count kinds and log overflow are covered, because a wrong design reports the wrong instance count or miscounts entries beyond the log depth. Byte ordering inside the 2x16 and 4x8 forms is checked byte by byte, and so is a flush that also rewrites the format, where a design that applies the write first reports the new format on the old batch.

// File: rtl/dd_pkg.sv
package dd_pkg;
  localparam int PUSH_MAX = 16;
  localparam int PUSH_NW  = $clog2(PUSH_MAX + 1);

  localparam logic [7:0] M_END   = 8'h00;
  localparam logic [7:0] M_BEGIN = 8'h01;
  localparam logic [7:0] M_VBF   = 8'h02;
  localparam logic [7:0] M_VBC   = 8'h03;
  localparam logic [7:0] M_IBF   = 8'h04;
  localparam logic [7:0] M_IBC   = 8'h05;
  localparam logic [7:0] M_INL32 = 8'h06;
  localparam logic [7:0] M_INL16 = 8'h07;
  localparam logic [7:0] M_INL8  = 8'h08;
  localparam logic [7:0] M_FMT   = 8'h10;

  typedef enum logic [3:0] {
    K_OTHER, K_END, K_BEGIN, K_VBF, K_VBC, K_IBF, K_IBC,
    K_INL32, K_INL16, K_INL8, K_FMT
  } mkind_e;

  localparam logic [1:0] INST_FIRST = 2'd0;
  localparam logic [1:0] INST_SUBSQ = 2'd1;
  localparam logic [1:0] INST_UNCHG = 2'd2;
  localparam logic [1:0] FMT_U32    = 2'd2;
endpackage

// File: rtl/dd_method_decode.sv
module dd_method_decode
  import dd_pkg::*;
#(
  parameter int METHOD_W = 8
) (
  input  logic [METHOD_W-1:0] method,
  input  logic [31:0]         data,
  output mkind_e              kind,
  output logic                is_draw,
  output logic [PUSH_NW-1:0]  push_n,
  output logic [8*PUSH_MAX-1:0] push_bytes
);
  logic [7:0] code;

  always_comb begin
    code = 8'(method);
    unique case (code)
      M_END:   kind = K_END;
      M_BEGIN: kind = K_BEGIN;
      M_VBF:   kind = K_VBF;
      M_VBC:   kind = K_VBC;
      M_IBF:   kind = K_IBF;
      M_IBC:   kind = K_IBC;
      M_INL32: kind = K_INL32;
      M_INL16: kind = K_INL16;
      M_INL8:  kind = K_INL8;
      M_FMT:   kind = K_FMT;
      default: kind = K_OTHER;
    endcase
    if (METHOD_W > 8 && (method >> 8) != '0) kind = K_OTHER;
    is_draw = (kind != K_OTHER) && (kind != K_FMT);
  end

  // Each index becomes a zero-extended 32-bit entry, low byte first.
  always_comb begin
    push_bytes = '0;
    push_n     = '0;
    unique case (kind)
      K_INL32: begin
        push_n = PUSH_NW'(4);
        push_bytes[31:0] = data;
      end
      K_INL16: begin
        push_n = PUSH_NW'(8);
        push_bytes[15:0]  = data[15:0];
        push_bytes[47:32] = data[31:16];
      end
      K_INL8: begin
        push_n = PUSH_NW'(16);
        for (int b = 0; b < 4; b++) push_bytes[b*32 +: 8] = data[b*8 +: 8];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dd_index_queue.sv
module dd_index_queue
  import dd_pkg::*;
#(
  parameter int QDEPTH = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   push_en,
  input  logic [PUSH_NW-1:0]     push_n,
  input  logic [8*PUSH_MAX-1:0]  push_bytes,
  input  logic                   clr,
  input  logic [$clog2(QDEPTH)-1:0] raddr,
  output logic [7:0]             rdata,
  output logic [$clog2(QDEPTH+1)-1:0] count,
  output logic                   ovf
);
  localparam int QCW = $clog2(QDEPTH + 1);
  localparam int LNW = $clog2(PUSH_MAX);

  logic [7:0]     mem [QDEPTH];
  logic [QCW-1:0] cnt_q, cnt_d;
  logic [QCW-1:0] space, take;
  logic           we [QDEPTH];
  logic [7:0]     wdat [QDEPTH];

  always_comb begin
    space = QCW'(QDEPTH) - cnt_q;
    if (QCW'(push_n) > space) take = space;
    else                      take = QCW'(push_n);
    ovf = push_en && (QCW'(push_n) > space);
  end

  always_comb begin
    for (int s = 0; s < QDEPTH; s++) begin
      logic [QCW:0] off;
      off     = (QCW+1)'(s) - {1'b0, cnt_q};
      we[s]   = push_en && ((QCW+1)'(s) >= {1'b0, cnt_q}) && (off < {1'b0, take});
      wdat[s] = push_bytes[8*off[LNW-1:0] +: 8];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (clr)          cnt_d = '0;
    else if (push_en) cnt_d = cnt_q + take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_ff @(posedge clk) begin
    for (int s = 0; s < QDEPTH; s++) begin
      if (we[s]) mem[s] <= wdat[s];
    end
  end

  assign rdata = mem[raddr];
  assign count = cnt_q;
endmodule

// File: rtl/dd_batch_eval.sv
module dd_batch_eval
  import dd_pkg::*;
#(
  parameter int LW  = 5,
  parameter int QCW = 7
) (
  input  logic [1:0]     inst_id,
  input  logic [LW-1:0]  vb_writes,
  input  logic [LW-1:0]  ib_writes,
  input  logic           last_was_ib,
  input  logic           inline_seen,
  input  logic [QCW-1:0] qbytes,
  input  logic [31:0]    vb_count,
  input  logic [31:0]    vb_first,
  input  logic [31:0]    ib_count,
  input  logic [31:0]    ib_first,
  input  logic [1:0]     idx_fmt,
  output logic           indexed,
  output logic [LW-1:0]  instances,
  output logic [31:0]    count,
  output logic [31:0]    first,
  output logic [1:0]     fmt,
  output logic [31:0]    vb_next,
  output logic [31:0]    ib_next,
  output logic           mixed
);
  logic        inst_mode;
  logic        use_inline;
  logic [31:0] ib_eff;

  always_comb begin
    inst_mode  = (inst_id == INST_SUBSQ) || (inst_id == INST_UNCHG);
    use_inline = !inst_mode && inline_seen;
    ib_eff     = use_inline ? 32'(qbytes >> 2) : ib_count;
    fmt        = use_inline ? FMT_U32 : idx_fmt;
    mixed      = inst_mode && (vb_writes != '0) && (ib_writes != '0);

    if (!inst_mode)  instances = LW'(1);
    else if (mixed)  instances = last_was_ib ? ib_writes : vb_writes;
    else             instances = (vb_writes != '0) ? vb_writes : ib_writes;

    indexed = (ib_eff != 32'd0) && (vb_count == 32'd0);
    count   = indexed ? ib_eff   : vb_count;
    first   = indexed ? ib_first : vb_first;
    vb_next = indexed ? vb_count : 32'd0;
    ib_next = indexed ? 32'd0    : ib_eff;
  end
endmodule

// File: rtl/dd_collector.sv
module dd_collector
  import dd_pkg::*;
#(
  parameter int METHOD_W  = 8,
  parameter int LOG_DEPTH = 16,
  parameter int QDEPTH    = 64,
  localparam int LW  = $clog2(LOG_DEPTH + 1),
  localparam int QAW = $clog2(QDEPTH),
  localparam int QCW = $clog2(QDEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [METHOD_W-1:0] wr_method,
  input  logic [31:0]         wr_data,
  input  logic                render_en,
  output logic                draw_valid,
  input  logic                draw_ready,
  output logic                draw_indexed,
  output logic [LW-1:0]       draw_instances,
  output logic [31:0]         draw_count,
  output logic [31:0]         draw_first,
  output logic [1:0]          draw_fmt,
  input  logic [QAW-1:0]      ixq_raddr,
  output logic [7:0]          ixq_rdata,
  output logic [QCW-1:0]      ixq_bytes,
  output logic                ovf_err,
  output logic                mix_err
);
  mkind_e                kind;
  logic                  is_draw;
  logic [PUSH_NW-1:0]    push_n;
  logic [8*PUSH_MAX-1:0] push_bytes;
  logic                  q_ovf, q_clr, q_push;

  logic [31:0] vbc_q, vbc_d, vbf_q, vbf_d, ibc_q, ibc_d, ibf_q, ibf_d;
  logic [1:0]  inst_q, inst_d, fmt_q, fmt_d;
  logic [LW-1:0] len_q, len_d, vbw_q, vbw_d, ibw_q, ibw_d;
  logic        lastib_q, lastib_d, inl_q, inl_d, end_q, end_d;
  logic        ovf_q, ovf_d, mix_q, mix_d, dv_q, dv_d;
  logic        o_ind_q, o_ind_d;
  logic [LW-1:0] o_inst_q, o_inst_d;
  logic [31:0] o_cnt_q, o_cnt_d, o_first_q, o_first_d;
  logic [1:0]  o_fmt_q, o_fmt_d;

  logic        ev_ind, ev_mixed;
  logic [LW-1:0] ev_inst;
  logic [31:0] ev_cnt, ev_first, ev_vbn, ev_ibn;
  logic [1:0]  ev_fmt;
  logic        acc, hs, eval, logged;

  dd_method_decode #(.METHOD_W(METHOD_W)) u_dec (
    .method(wr_method), .data(wr_data), .kind(kind), .is_draw(is_draw),
    .push_n(push_n), .push_bytes(push_bytes)
  );

  dd_index_queue #(.QDEPTH(QDEPTH)) u_q (
    .clk(clk), .rst_n(rst_n), .push_en(q_push), .push_n(push_n),
    .push_bytes(push_bytes), .clr(q_clr), .raddr(ixq_raddr),
    .rdata(ixq_rdata), .count(ixq_bytes), .ovf(q_ovf)
  );

  dd_batch_eval #(.LW(LW), .QCW(QCW)) u_ev (
    .inst_id(inst_q), .vb_writes(vbw_q), .ib_writes(ibw_q),
    .last_was_ib(lastib_q), .inline_seen(inl_q), .qbytes(ixq_bytes),
    .vb_count(vbc_q), .vb_first(vbf_q), .ib_count(ibc_q), .ib_first(ibf_q),
    .idx_fmt(fmt_q), .indexed(ev_ind), .instances(ev_inst), .count(ev_cnt),
    .first(ev_first), .fmt(ev_fmt), .vb_next(ev_vbn), .ib_next(ev_ibn),
    .mixed(ev_mixed)
  );

  always_comb begin
    acc    = wr_valid && !dv_q;
    hs     = dv_q && draw_ready;
    eval   = acc && !is_draw && end_q;
    logged = len_q < LW'(LOG_DEPTH);
    q_push = acc && is_draw && (push_n != '0);
    q_clr  = hs || (eval && !render_en);
  end

  always_comb begin
    vbc_d = vbc_q; vbf_d = vbf_q; ibc_d = ibc_q; ibf_d = ibf_q;
    inst_d = inst_q; fmt_d = fmt_q; len_d = len_q; vbw_d = vbw_q;
    ibw_d = ibw_q; lastib_d = lastib_q; inl_d = inl_q; end_d = end_q;
    ovf_d = ovf_q; mix_d = 1'b0; dv_d = dv_q;
    o_ind_d = o_ind_q; o_inst_d = o_inst_q; o_cnt_d = o_cnt_q;
    o_first_d = o_first_q; o_fmt_d = o_fmt_q;

    if (hs) dv_d = 1'b0;

    if (eval) begin
      dv_d      = render_en;
      o_ind_d   = ev_ind;
      o_inst_d  = ev_inst;
      o_cnt_d   = ev_cnt;
      o_first_d = ev_first;
      o_fmt_d   = ev_fmt;
      vbc_d     = ev_vbn;
      ibc_d     = ev_ibn;
      fmt_d     = ev_fmt;
      mix_d     = ev_mixed;
      len_d = '0; vbw_d = '0; ibw_d = '0;
      inl_d = 1'b0; end_d = 1'b0; ovf_d = 1'b0;
    end

    // The format write lands after any flush it caused.
    if (acc && kind == K_FMT) fmt_d = wr_data[1:0];

    if (acc && is_draw) begin
      end_d = (kind == K_END);
      if (logged) len_d = len_q + LW'(1);
      else        ovf_d = 1'b1;
      unique case (kind)
        K_BEGIN: inst_d = wr_data[1:0];
        K_VBF:   vbf_d  = wr_data;
        K_IBF:   ibf_d  = wr_data;
        K_VBC: begin
          vbc_d = wr_data;
          if (logged) begin vbw_d = vbw_q + LW'(1); lastib_d = 1'b0; end
        end
        K_IBC: begin
          ibc_d = wr_data;
          if (logged) begin ibw_d = ibw_q + LW'(1); lastib_d = 1'b1; end
        end
        K_INL32, K_INL16, K_INL8: inl_d = 1'b1;
        default: ;
      endcase
    end

    if (q_ovf) ovf_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vbc_q <= '0; vbf_q <= '0; ibc_q <= '0; ibf_q <= '0;
      inst_q <= INST_FIRST; fmt_q <= '0; len_q <= '0; vbw_q <= '0;
      ibw_q <= '0; lastib_q <= 1'b0; inl_q <= 1'b0; end_q <= 1'b0;
      ovf_q <= 1'b0; mix_q <= 1'b0; dv_q <= 1'b0;
    end else begin
      vbc_q <= vbc_d; vbf_q <= vbf_d; ibc_q <= ibc_d; ibf_q <= ibf_d;
      inst_q <= inst_d; fmt_q <= fmt_d; len_q <= len_d; vbw_q <= vbw_d;
      ibw_q <= ibw_d; lastib_q <= lastib_d; inl_q <= inl_d; end_q <= end_d;
      ovf_q <= ovf_d; mix_q <= mix_d; dv_q <= dv_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      o_ind_q <= 1'b0; o_inst_q <= '0; o_cnt_q <= '0;
      o_first_q <= '0; o_fmt_q <= '0;
    end else if (eval) begin
      o_ind_q <= o_ind_d; o_inst_q <= o_inst_d; o_cnt_q <= o_cnt_d;
      o_first_q <= o_first_d; o_fmt_q <= o_fmt_d;
    end
  end

  assign wr_ready       = !dv_q;
  assign draw_valid     = dv_q;
  assign draw_indexed   = o_ind_q;
  assign draw_instances = o_inst_q;
  assign draw_count     = o_cnt_q;
  assign draw_first     = o_first_q;
  assign draw_fmt       = o_fmt_q;
  assign ovf_err        = ovf_q;
  assign mix_err        = mix_q;
endmodule

// File: rtl/dd_collector_chk.sv
module dd_collector_chk #(
  parameter int LW  = 5,
  parameter int QCW = 7,
  parameter int QDEPTH = 64
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_valid,
  input logic           draw_valid,
  input logic           draw_ready,
  input logic           draw_indexed,
  input logic [LW-1:0]  draw_instances,
  input logic [31:0]    draw_count,
  input logic [QCW-1:0] ixq_bytes,
  input logic           mix_err
);
  // R9
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    draw_valid && !draw_ready |=> draw_valid && $stable(draw_count)
      && $stable(draw_instances) && $stable(draw_indexed));

  // R9
  req_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(draw_valid) |-> $past(draw_ready));

  // R3
  req_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(draw_valid) |-> $past(wr_valid));

  // R5
  mix_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mix_err |=> !mix_err);

  // R7
  idx_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    draw_valid && draw_indexed |-> draw_count != 32'd0);

  // R10
  queue_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ixq_bytes <= QCW'(QDEPTH));
endmodule

bind dd_collector dd_collector_chk #(.LW(LW), .QCW(QCW), .QDEPTH(QDEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .draw_valid(draw_valid),
  .draw_ready(draw_ready), .draw_indexed(draw_indexed),
  .draw_instances(draw_instances), .draw_count(draw_count),
  .ixq_bytes(ixq_bytes), .mix_err(mix_err)
);

// File: tb/dd_collector_test.sv
`timescale 1ns/1ps
module dd_collector_test;
  localparam int LD = 16;
  localparam int QD = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_method = '0;
  logic [31:0] wr_data = '0;
  logic render_en = 1'b1;
  logic draw_valid;
  logic draw_ready = 1'b0;
  logic draw_indexed;
  logic [4:0] draw_instances;
  logic [31:0] draw_count, draw_first;
  logic [1:0] draw_fmt;
  logic [5:0] ixq_raddr = '0;
  logic [7:0] ixq_rdata;
  logic [6:0] ixq_bytes;
  logic ovf_err, mix_err;

  always #4 clk = ~clk;

  dd_collector uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_method(wr_method), .wr_data(wr_data), .render_en(render_en),
    .draw_valid(draw_valid), .draw_ready(draw_ready), .draw_indexed(draw_indexed),
    .draw_instances(draw_instances), .draw_count(draw_count), .draw_first(draw_first),
    .draw_fmt(draw_fmt), .ixq_raddr(ixq_raddr), .ixq_rdata(ixq_rdata),
    .ixq_bytes(ixq_bytes), .ovf_err(ovf_err), .mix_err(mix_err)
  );

  int tests = 0, fails = 0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference ----------------
  longint vbc, vbf, ibc, ibf;
  int inst, fmt, loglen, vbw, ibw;
  bit lastib, inl, lastend, ovf, mv, mix;
  logic [7:0] q[$];
  bit m_ind; int m_inst; longint m_cnt, m_first; int m_fmt;

  task automatic push_byte(input logic [7:0] b);
    if (q.size() < QD) q.push_back(b); else ovf = 1;
  endtask
  task automatic push_word(input logic [31:0] w);
    for (int i = 0; i < 4; i++) push_byte(w[i*8 +: 8]);
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      vbc = 0; vbf = 0; ibc = 0; ibf = 0; inst = 0; fmt = 0; loglen = 0;
      vbw = 0; ibw = 0; lastib = 0; inl = 0; lastend = 0; ovf = 0; mv = 0;
      mix = 0; q.delete(); m_ind = 0; m_inst = 0; m_cnt = 0; m_first = 0; m_fmt = 0;
    end else begin
      bit acc, isdraw;
      acc = wr_valid && !mv;
      isdraw = wr_method <= 8'h08;
      mix = 0;
      if (mv && draw_ready) begin mv = 0; q.delete(); end
      if (acc && !isdraw) begin
        if (lastend) begin
          bit im, useinl; longint ibe;
          im = (inst == 1 || inst == 2);
          useinl = !im && inl;
          ibe = useinl ? q.size() / 4 : ibc;
          m_fmt = useinl ? 2 : fmt;
          fmt = m_fmt;
          mix = im && vbw != 0 && ibw != 0;
          if (!im) m_inst = 1;
          else if (vbw != 0 && ibw != 0) m_inst = lastib ? ibw : vbw;
          else m_inst = vbw + ibw;
          m_ind = (ibe != 0) && (vbc == 0);
          m_cnt = m_ind ? ibe : vbc;
          m_first = m_ind ? ibf : vbf;
          if (m_ind) ibc = 0; else begin ibc = ibe; vbc = 0; end
          loglen = 0; vbw = 0; ibw = 0; inl = 0; lastend = 0; ovf = 0;
          mv = render_en;
          if (!render_en) q.delete();
        end
        if (wr_method == 8'h10) fmt = wr_data[1:0];
      end else if (acc) begin
        bit lg;
        lg = loglen < LD;
        if (lg) loglen++; else ovf = 1;
        lastend = (wr_method == 8'h00);
        case (wr_method)
          8'h01: inst = wr_data[1:0];
          8'h02: vbf = wr_data;
          8'h04: ibf = wr_data;
          8'h03: begin vbc = wr_data; if (lg) begin vbw++; lastib = 0; end end
          8'h05: begin ibc = wr_data; if (lg) begin ibw++; lastib = 1; end end
          8'h06: begin inl = 1; push_word(wr_data); end
          8'h07: begin inl = 1; push_word({16'h0, wr_data[15:0]}); push_word({16'h0, wr_data[31:16]}); end
          8'h08: begin inl = 1; for (int i = 0; i < 4; i++) push_word({24'h0, wr_data[i*8 +: 8]}); end
          default: ;
        endcase
      end
    end
  end

  // ---------------- draw capture (RTL handshakes) ----------------
  int ndraws = 0; bit c_ind; int c_inst; longint c_cnt, c_first; int c_fmt; bit mix_seen = 0;
  always @(posedge clk) begin
    if (rst_n && draw_valid && draw_ready) begin
      ndraws++; c_ind = draw_indexed; c_inst = draw_instances;
      c_cnt = draw_count; c_first = draw_first; c_fmt = draw_fmt;
    end
    if (rst_n && mix_err) mix_seen = 1;
  end

  // ---------------- per-cycle comparison ----------------
  bit started = 0, rd_ok = 0; int pend = 0, rd_idx = 0, hold = 2;
  always @(negedge clk) begin
    if (rst_n && started) begin
      chk(wr_ready == !mv, "R9 wr_ready", wr_ready, !mv);
      chk(draw_valid == mv, "R3 draw_valid", draw_valid, mv);
      if (mv) begin
        chk(draw_indexed == m_ind, "R7 indexed", draw_indexed, m_ind);
        chk(draw_instances == m_inst, "R4 instances", draw_instances, m_inst);
        chk(draw_count == m_cnt, "R6 count", draw_count, m_cnt);
        chk(draw_first == m_first, "R7 first", draw_first, m_first);
        chk(draw_fmt == m_fmt, "R12 fmt", draw_fmt, m_fmt);
        if (rd_ok && rd_idx < q.size())
          chk(ixq_rdata == q[rd_idx], "R2 byte", ixq_rdata, q[rd_idx]);
      end
      chk(ixq_bytes == q.size(), "R2 bytes", ixq_bytes, q.size());
      chk(ovf_err == ovf, "R10 ovf", ovf_err, ovf);
      chk(mix_err == mix, "R5 mix", mix_err, mix);
    end
    if (mv) begin
      if (rd_ok) rd_idx = (rd_idx + 1 < q.size()) ? rd_idx + 1 : 0;
      pend++;
    end else begin pend = 0; rd_idx = 0; end
    rd_ok = mv;
    ixq_raddr = 6'(rd_idx);
    draw_ready = mv && (pend > hold);
  end

  // ---------------- stimulus ----------------
  task automatic wr(input logic [7:0] m, input logic [31:0] d);
    @(negedge clk);
    while (!wr_ready) @(negedge clk);
    wr_valid = 1; wr_method = m; wr_data = d;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
    while (draw_valid) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic exp_draw(input int n0, input bit ind, input int ins, input longint cnt,
                          input longint fst, input int fm, input string tag);
    chk(ndraws == n0 + 1, {tag, " draw issued"}, ndraws, n0 + 1);
    chk(c_ind == ind, {tag, " indexed"}, c_ind, ind);
    chk(c_inst == ins, {tag, " instances"}, c_inst, ins);
    chk(c_cnt == cnt, {tag, " count"}, c_cnt, cnt);
    chk(c_first == fst, {tag, " first"}, c_first, fst);
    chk(c_fmt == fm, {tag, " fmt"}, c_fmt, fm);
  endtask

  int n0;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(draw_valid == 0, "R11 valid", draw_valid, 0);
    chk(wr_ready == 1, "R11 ready", wr_ready, 1);
    chk(ixq_bytes == 0, "R11 bytes", ixq_bytes, 0);
    chk(ovf_err == 0 && mix_err == 0, "R11 errs", {ovf_err, mix_err}, 0);
    started = 1;

    // R1 direct draw, flushed by an unrelated code
    n0 = ndraws;
    wr(8'h01, 0); wr(8'h02, 5); wr(8'h03, 12); wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 0, 1, 12, 5, 0, "R1");

    // R3 no draw without draw end
    n0 = ndraws;
    wr(8'h03, 7); wr(8'h20, 0); settle();
    chk(ndraws == n0, "R3 no draw", ndraws, n0);
    wr(8'h00, 0); wr(8'h21, 0); settle();
    exp_draw(n0, 0, 1, 7, 5, 0, "R3");

    // R7 indexed, then index count cleared
    n0 = ndraws;
    wr(8'h04, 3); wr(8'h05, 9); wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 1, 1, 9, 3, 0, "R7");
    n0 = ndraws;
    wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 0, 1, 0, 5, 0, "R7 cleared");

    // R4 instance counting
    n0 = ndraws;
    wr(8'h01, 1); wr(8'h03, 4); wr(8'h03, 4); wr(8'h03, 4); wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 0, 3, 4, 5, 0, "R4");
    n0 = ndraws;
    wr(8'h01, 2); wr(8'h05, 6); wr(8'h05, 6); wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 1, 2, 6, 3, 0, "R4 unchanged");

    // R5 mixed kinds
    n0 = ndraws; mix_seen = 0;
    wr(8'h01, 1); wr(8'h03, 2); wr(8'h05, 3); wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 0, 1, 2, 5, 0, "R5");
    chk(mix_seen == 1, "R5 mix_err", mix_seen, 1);
    n0 = ndraws;
    wr(8'h01, 0); wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 1, 1, 3, 3, 0, "R7 kept index count");

    // R2 / R6 inline indices, long hold to read all bytes
    hold = 32; n0 = ndraws;
    wr(8'h06, 32'h44332211); wr(8'h07, 32'hBBBBAAAA); wr(8'h08, 32'h04030201);
    chk(ixq_bytes == 28, "R2 queue fill", ixq_bytes, 28);
    wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 1, 1, 7, 3, 2, "R6");
    chk(ixq_bytes == 0, "R9 queue emptied", ixq_bytes, 0);
    hold = 2;

    // R8 render disabled
    n0 = ndraws;
    wr(8'h10, 0); wr(8'h03, 5); wr(8'h00, 0); render_en = 0; wr(8'h20, 0); settle();
    chk(ndraws == n0, "R8 suppressed", ndraws, n0);
    render_en = 1;
    wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 0, 1, 0, 5, 0, "R8 count cleared");

    // R12 format write that also flushes
    n0 = ndraws;
    wr(8'h10, 1); wr(8'h05, 2); wr(8'h00, 0); wr(8'h10, 0); settle();
    exp_draw(n0, 1, 1, 2, 3, 1, "R12");
    n0 = ndraws;
    wr(8'h05, 3); wr(8'h00, 0); wr(8'h20, 0); settle();
    exp_draw(n0, 1, 1, 3, 3, 0, "R12 after");

    // R10 queue overflow
    hold = 70; n0 = ndraws;
    wr(8'h01, 0);
    for (int i = 0; i < 5; i++) wr(8'h08, 32'h01020304 + i);
    wr(8'h00, 0);
    chk(ovf_err == 1, "R10 queue ovf", ovf_err, 1);
    chk(ixq_bytes == QD, "R10 queue full", ixq_bytes, QD);
    wr(8'h20, 0); settle();
    exp_draw(n0, 1, 1, 16, 3, 2, "R10");
    hold = 2;

    // R10 log overflow in instance mode
    n0 = ndraws;
    wr(8'h01, 1);
    for (int i = 0; i < 17; i++) wr(8'h03, 8);
    wr(8'h00, 0);
    chk(ovf_err == 1, "R10 log ovf", ovf_err, 1);
    wr(8'h20, 0); settle();
    exp_draw(n0, 0, 15, 8, 5, 2, "R10 log");
    chk(ovf_err == 0, "R10 ovf cleared", ovf_err, 0);

    repeat (4) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule